// File: doc/BRIEF.md
# Bus-Snooping Video Shadow Controller

This block sits beside an 8-bit host processor bus and watches every bus cycle without ever taking part in one. It keeps a private copy of the state that a video generator needs. Each RAM write is sent to either a main or an auxiliary shadow-memory write port. The choice depends on the banking switches as they stand when the write happens. Accesses to the switch I/O page (addresses 0xC000 to 0xC07F) update a vector of mode flags, a two-bit double-graphics mode register and two colour registers.

Two machine-class inputs decide which switches are live. `sys_enh` turns on the enhanced register set. `sys_gfx` turns on the extended graphics set. Some switches need one of the two, some need a particular one, and the display switches work on every machine class.

The bus is observed, not driven, so it cannot be stalled. For that reason there is no valid/ready handshake here. A bus cycle counts when `bus_valid` is high at a rising clock edge. Every effect of that cycle, whether a write strobe or a register change, appears right after that same edge. The shadow write ports are single-cycle strobes with no back-pressure, so the memories behind them must accept one write per cycle.

Top module: `video_shadow_snoop`

## Requirements
- R1: After reset, `mode_flags`, `dbl_mode`, `text_color` and `border_color` are all zero, and neither write strobe is high.
- R2: A valid write to an address from 0x0200 to 0xBFFF drives exactly one of `main_we`/`aux_we` high for one cycle, starting at the clock edge that samples the write. The matching address and data outputs carry the bus address and data. A write below 0x0200, a write at 0xC000 or above, and any read all leave both strobes low.
- R3: While flag bit 0 (page-store) is set, the auxiliary-write flag is ignored. Writes go to the auxiliary port when flag bit 7 (page 2) is set and the address is from 0x0400 to 0x07FF. They also go there when bits 7 and 8 (hi-res) are both set and the address is from 0x2000 to 0x3FFF. Every other RAM write goes to the main port.
- R4: While flag bit 0 is clear and flag bit 1 (auxiliary-write) is set, every RAM write goes to the auxiliary port.
- R5: While flag bits 0 and 1 are both clear, every RAM write goes to the main port.
- R6: Five switch pairs use offsets (address bits 6:0) 0x00/0x01, 0x04/0x05, 0x08/0x09, 0x0C/0x0D and 0x0E/0x0F. These clear (even offset) or set (odd offset) flag bits 0, 1, 2, 3 (80-column) and 4 (alternate characters) in that order. They act only on write cycles, and only while `sys_enh` or `sys_gfx` is high.
- R7: Offsets 0x50/0x51, 0x52/0x53, 0x54/0x55 and 0x56/0x57 clear or set flag bits 5 (text), 6 (mixed), 7 (page 2) and 8 (hi-res). They act on reads and writes alike, on every machine class.
- R8: A write to offset 0x21 copies bus data bit 7 into flag bit 9 (monochrome), but only while `sys_enh` or `sys_gfx` is high.
- R9: Any access to offset 0x5E sets flag bit 10 (double-graphics arm) while `sys_enh` or `sys_gfx` is high. Any access to offset 0x5F while bit 10 is set shifts `dbl_mode`: the new bit 1 takes the old bit 0, and the new bit 0 takes flag bit 3. That same access then clears bit 10 if `sys_enh` or `sys_gfx` is high. An access to 0x5F while bit 10 is clear leaves `dbl_mode` unchanged.
- R10: A write to offset 0x7E sets flag bit 11 (I/O lock), and a write to 0x7F clears it, only while `sys_enh` is high. Reads have no effect.
- R11: While `sys_gfx` is high, a write to offset 0x22 loads `text_color` from the bus data, and a write to offset 0x34 loads `border_color` from the low four data bits. Reads, and writes made while `sys_gfx` is low, leave both registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Host bus cycle present this clock |
| bus_write | input | 1 | 1 = write cycle, 0 = read cycle |
| bus_addr | input | 16 | Host bus address |
| bus_data | input | 8 | Host bus data |
| sys_enh | input | 1 | Enhanced register set enable |
| sys_gfx | input | 1 | Extended graphics register set enable |
| main_we | output | 1 | Main shadow write strobe |
| main_addr | output | 16 | Main shadow write address |
| main_data | output | 8 | Main shadow write data |
| aux_we | output | 1 | Auxiliary shadow write strobe |
| aux_addr | output | 16 | Auxiliary shadow write address |
| aux_data | output | 8 | Auxiliary shadow write data |
| mode_flags | output | 12 | Mode flag vector (bit map in R3 to R10) |
| dbl_mode | output | 2 | Double-graphics mode register |
| text_color | output | 8 | Text/background colour |
| border_color | output | 4 | Border colour |

## Verification
The checker watches every cycle for the following:
- at most one write strobe is high at a time;
- writes below the RAM window produce no strobe;
- a text-set access forces the text flag on;
- reads to a pair switch leave its flag alone;
- a 0x5F access while disarmed leaves the mode register unchanged;
- an I/O-lock access without the enhanced set has no effect;
- the border colour holds when no graphics-set write occurs.

Only the bench scenarios can show the rest: the full routing precedence between page-store, page 2, hi-res and auxiliary-write; the exact data paths onto the two ports; and the shift order of the double-graphics register across several strobes with the 80-column flag changing between them.

// File: rtl/vsh_pkg.sv
package vsh_pkg;
  localparam int NFLAG = 12;

  localparam int FL_PGSTORE = 0;
  localparam int FL_AUXWR   = 1;
  localparam int FL_AUXZP   = 2;
  localparam int FL_WIDE    = 3;
  localparam int FL_ALTSET  = 4;
  localparam int FL_TEXT    = 5;
  localparam int FL_MIX     = 6;
  localparam int FL_PG2     = 7;
  localparam int FL_HIRES   = 8;
  localparam int FL_MONO    = 9;
  localparam int FL_DBLARM  = 10;
  localparam int FL_IOLOCK  = 11;

  localparam int NPAIR = 5;

  localparam logic [6:0] OFF_MONO    = 7'h21;
  localparam logic [6:0] OFF_TXTCOL  = 7'h22;
  localparam logic [6:0] OFF_BORDER  = 7'h34;
  localparam logic [6:0] OFF_ARM     = 7'h5E;
  localparam logic [6:0] OFF_SHIFT   = 7'h5F;
  localparam logic [6:0] OFF_LOCKSET = 7'h7E;
  localparam logic [6:0] OFF_LOCKCLR = 7'h7F;

  typedef enum logic [1:0] {
    RT_NONE = 2'd0,
    RT_MAIN = 2'd1,
    RT_AUX  = 2'd2
  } route_e;

  function automatic logic [6:0] pair_base(input int idx);
    case (idx)
      0:       pair_base = 7'h00;
      1:       pair_base = 7'h04;
      2:       pair_base = 7'h08;
      3:       pair_base = 7'h0C;
      default: pair_base = 7'h0E;
    endcase
  endfunction
endpackage

// File: rtl/vsh_wport.sv
module vsh_wport #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] data_in,
  output logic          we,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      we   <= 1'b0;
      addr <= '0;
      data <= '0;
    end else begin
      we <= sel;
      if (sel) begin
        addr <= addr_in;
        data <= data_in;
      end
    end
  end
endmodule

// File: rtl/vsh_route.sv
module vsh_route
  import vsh_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter logic [AW-1:0] RAM_LO = 'h0200,
  parameter logic [AW-1:0] RAM_HI = 'hBFFF,
  parameter logic [AW-1:0] TXT_LO = 'h0400,
  parameter logic [AW-1:0] TXT_HI = 'h07FF,
  parameter logic [AW-1:0] HGR_LO = 'h2000,
  parameter logic [AW-1:0] HGR_HI = 'h3FFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid,
  input  logic             write,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    data,
  input  logic [NFLAG-1:0] flags,
  output logic             main_we,
  output logic [AW-1:0]    main_addr,
  output logic [DW-1:0]    main_data,
  output logic             aux_we,
  output logic [AW-1:0]    aux_addr,
  output logic [DW-1:0]    aux_data
);
  localparam int NPORT = 2;

  logic   in_ram, in_txt, in_hgr, to_aux;
  route_e route;
  logic [NPORT-1:0]    sel;
  logic [NPORT-1:0]    we_v;
  logic [AW-1:0]       addr_v [NPORT];
  logic [DW-1:0]       data_v [NPORT];

  always_comb begin
    in_ram = (addr >= RAM_LO) && (addr <= RAM_HI);
    in_txt = (addr >= TXT_LO) && (addr <= TXT_HI);
    in_hgr = (addr >= HGR_LO) && (addr <= HGR_HI);
    if (flags[FL_PGSTORE])
      to_aux = flags[FL_PG2] && (in_txt || (flags[FL_HIRES] && in_hgr));
    else
      to_aux = flags[FL_AUXWR];
    if (valid && write && in_ram)
      route = to_aux ? RT_AUX : RT_MAIN;
    else
      route = RT_NONE;
    sel[0] = (route == RT_MAIN);
    sel[1] = (route == RT_AUX);
  end

  for (genvar k = 0; k < NPORT; k++) begin : g_port
    vsh_wport #(.AW(AW), .DW(DW)) u_wport (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel     (sel[k]),
      .addr_in (addr),
      .data_in (data),
      .we      (we_v[k]),
      .addr    (addr_v[k]),
      .data    (data_v[k])
    );
  end

  assign main_we   = we_v[0];
  assign main_addr = addr_v[0];
  assign main_data = data_v[0];
  assign aux_we    = we_v[1];
  assign aux_addr  = addr_v[1];
  assign aux_data  = data_v[1];
endmodule

// File: rtl/vsh_switch.sv
module vsh_switch
  import vsh_pkg::*;
#(
  parameter int DW = 8,
  parameter int MW = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit,
  input  logic             write,
  input  logic [6:0]       off,
  input  logic [DW-1:0]    data,
  input  logic             sys_enh,
  input  logic             sys_gfx,
  output logic [NFLAG-1:0] flags,
  output logic [MW-1:0]    mode
);
  logic             ext;
  logic [NFLAG-1:0] flags_n;
  logic [MW-1:0]    mode_n;

  assign ext = sys_enh | sys_gfx;

  always_comb begin
    flags_n = flags;
    mode_n  = mode;
    if (hit) begin
      for (int i = 0; i < NPAIR; i++) begin
        if (ext && write && (off[6:1] == pair_base(i)[6:1]))
          flags_n[i] = off[0];
      end
      if (off[6:3] == 4'b1010)
        flags_n[FL_TEXT + int'(off[2:1])] = off[0];
      case (off)
        OFF_MONO:    if (ext && write) flags_n[FL_MONO] = data[DW-1];
        OFF_ARM:     if (ext) flags_n[FL_DBLARM] = 1'b1;
        OFF_SHIFT: begin
          if (flags[FL_DBLARM])
            mode_n = {mode[MW-2:0], flags[FL_WIDE]};
          if (ext) flags_n[FL_DBLARM] = 1'b0;
        end
        OFF_LOCKSET: if (sys_enh && write) flags_n[FL_IOLOCK] = 1'b1;
        OFF_LOCKCLR: if (sys_enh && write) flags_n[FL_IOLOCK] = 1'b0;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags <= '0;
      mode  <= '0;
    end else begin
      flags <= flags_n;
      mode  <= mode_n;
    end
  end
endmodule

// File: rtl/vsh_color.sv
module vsh_color
  import vsh_pkg::*;
#(
  parameter int DW = 8,
  parameter int BW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hit,
  input  logic          write,
  input  logic [6:0]    off,
  input  logic [DW-1:0] data,
  input  logic          sys_gfx,
  output logic [DW-1:0] text_color,
  output logic [BW-1:0] border_color
);
  logic load;
  assign load = hit && write && sys_gfx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      text_color   <= '0;
      border_color <= '0;
    end else if (load) begin
      if (off == OFF_TXTCOL) text_color <= data;
      if (off == OFF_BORDER) border_color <= data[BW-1:0];
    end
  end
endmodule

// File: rtl/video_shadow_snoop.sv
module video_shadow_snoop
  import vsh_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int BW = 4,
  parameter int MW = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_valid,
  input  logic             bus_write,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_data,
  input  logic             sys_enh,
  input  logic             sys_gfx,
  output logic             main_we,
  output logic [AW-1:0]    main_addr,
  output logic [DW-1:0]    main_data,
  output logic             aux_we,
  output logic [AW-1:0]    aux_addr,
  output logic [DW-1:0]    aux_data,
  output logic [NFLAG-1:0] mode_flags,
  output logic [MW-1:0]    dbl_mode,
  output logic [DW-1:0]    text_color,
  output logic [BW-1:0]    border_color
);
  localparam logic [AW-8:0] IO_PAGE = (AW-7)'('h180);

  logic       io_hit;
  logic [6:0] io_off;

  assign io_off = bus_addr[6:0];
  assign io_hit = bus_valid && (bus_addr[AW-1:7] == IO_PAGE);

  vsh_route #(.AW(AW), .DW(DW)) u_route (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid     (bus_valid),
    .write     (bus_write),
    .addr      (bus_addr),
    .data      (bus_data),
    .flags     (mode_flags),
    .main_we   (main_we),
    .main_addr (main_addr),
    .main_data (main_data),
    .aux_we    (aux_we),
    .aux_addr  (aux_addr),
    .aux_data  (aux_data)
  );

  vsh_switch #(.DW(DW), .MW(MW)) u_switch (
    .clk     (clk),
    .rst_n   (rst_n),
    .hit     (io_hit),
    .write   (bus_write),
    .off     (io_off),
    .data    (bus_data),
    .sys_enh (sys_enh),
    .sys_gfx (sys_gfx),
    .flags   (mode_flags),
    .mode    (dbl_mode)
  );

  vsh_color #(.DW(DW), .BW(BW)) u_color (
    .clk          (clk),
    .rst_n        (rst_n),
    .hit          (io_hit),
    .write        (bus_write),
    .off          (io_off),
    .data         (bus_data),
    .sys_gfx      (sys_gfx),
    .text_color   (text_color),
    .border_color (border_color)
  );
endmodule

// File: rtl/vsh_checker.sv
module vsh_checker
  import vsh_pkg::*;
#(
  parameter int AW = 16,
  parameter int BW = 4,
  parameter int MW = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_valid,
  input logic             bus_write,
  input logic [AW-1:0]    bus_addr,
  input logic             sys_enh,
  input logic             sys_gfx,
  input logic             main_we,
  input logic             aux_we,
  input logic [NFLAG-1:0] mode_flags,
  input logic [MW-1:0]    dbl_mode,
  input logic [BW-1:0]    border_color
);
  logic io_acc;
  assign io_acc = bus_valid && (bus_addr[AW-1:7] == (AW-7)'('h180));

  a_r2_one_port: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({main_we, aux_we}));

  a_r2_low_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && bus_addr < AW'('h0200)) |=> (!main_we && !aux_we));

  a_r7_text_set: assert property (@(posedge clk) disable iff (!rst_n)
    (io_acc && bus_addr[6:0] == 7'h51) |=> mode_flags[FL_TEXT]);

  a_r6_read_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    (io_acc && !bus_write && bus_addr[6:0] == 7'h01) |=> $stable(mode_flags[FL_PGSTORE]));

  a_r9_disarmed_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (io_acc && bus_addr[6:0] == 7'h5F && !mode_flags[FL_DBLARM]) |=> $stable(dbl_mode));

  a_r10_lock_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (io_acc && !sys_enh && bus_addr[6:1] == 6'h3F) |=> $stable(mode_flags[FL_IOLOCK]));

  a_r11_border_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_acc && bus_write && sys_gfx) |=> $stable(border_color));
endmodule

bind video_shadow_snoop vsh_checker #(.AW(AW), .BW(BW), .MW(MW)) u_vsh_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_valid    (bus_valid),
  .bus_write    (bus_write),
  .bus_addr     (bus_addr),
  .sys_enh      (sys_enh),
  .sys_gfx      (sys_gfx),
  .main_we      (main_we),
  .aux_we       (aux_we),
  .mode_flags   (mode_flags),
  .dbl_mode     (dbl_mode),
  .border_color (border_color)
);

// File: tb/test_video_shadow_snoop.sv
`timescale 1ns/1ps
module test_video_shadow_snoop;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_data = '0;
  logic        sys_enh = 1'b0, sys_gfx = 1'b0;
  logic        main_we, aux_we;
  logic [15:0] main_addr, aux_addr;
  logic [7:0]  main_data, aux_data;
  logic [11:0] mode_flags;
  logic [1:0]  dbl_mode;
  logic [7:0]  text_color;
  logic [3:0]  border_color;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  video_shadow_snoop i_video_shadow_snoop (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one bus cycle; returns at the next falling edge, when its effects are visible
  task automatic cyc(input logic wr, input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_data = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic expect_route(input string req, input logic [15:0] a, input logic [7:0] d, input int port);
    cyc(1'b1, a, d);
    check(req, {31'd0, main_we}, (port == 1) ? 1 : 0);
    check(req, {31'd0, aux_we},  (port == 2) ? 1 : 0);
    if (port == 1) check(req, {main_addr, main_data}, {a, d});
    if (port == 2) check(req, {aux_addr, aux_data}, {a, d});
  endtask

  task automatic t_reset;
    check("R1 flags", mode_flags, 0);
    check("R1 mode", dbl_mode, 0);
    check("R1 colours", {text_color, border_color}, 0);
    check("R1 strobes", {main_we, aux_we}, 0);
  endtask

  task automatic t_main;
    sys_enh = 1'b0; sys_gfx = 1'b0;
    expect_route("R5 main", 16'h1234, 8'h5A, 1);
    expect_route("R2 low edge", 16'h0200, 8'h11, 1);
    expect_route("R2 high edge", 16'hBFFF, 8'h22, 1);
    expect_route("R2 below window", 16'h01FF, 8'h33, 0);
    expect_route("R2 io page", 16'hC100, 8'h44, 0);
    cyc(1'b0, 16'h1000, 8'h00);
    check("R2 read", {main_we, aux_we}, 0);
  endtask

  task automatic t_auxwr;
    sys_enh = 1'b1;
    cyc(1'b1, 16'hC005, 8'h00);
    check("R6 aux-write set", mode_flags[1], 1);
    expect_route("R4 aux", 16'h0300, 8'h66, 2);
    expect_route("R4 aux high", 16'h9000, 8'h67, 2);
    cyc(1'b0, 16'hC004, 8'h00);
    check("R6 read ignored", mode_flags[1], 1);
    cyc(1'b1, 16'hC004, 8'h00);
    check("R6 aux-write clear", mode_flags[1], 0);
  endtask

  task automatic t_pgstore;
    sys_enh = 1'b1;
    cyc(1'b1, 16'hC001, 8'h00);
    check("R6 page-store set", mode_flags[0], 1);
    cyc(1'b1, 16'hC005, 8'h00);
    expect_route("R3 no page2 main", 16'h0500, 8'h70, 1);
    cyc(1'b0, 16'hC055, 8'h00);
    check("R7 page2 via read", mode_flags[7], 1);
    expect_route("R3 text aux", 16'h0500, 8'h71, 2);
    expect_route("R3 hgr no hires", 16'h2100, 8'h72, 1);
    cyc(1'b0, 16'hC057, 8'h00);
    expect_route("R3 hgr with hires", 16'h2100, 8'h73, 2);
    expect_route("R3 outside main", 16'h5000, 8'h74, 1);
    cyc(1'b1, 16'hC054, 8'h00);
    cyc(1'b1, 16'hC056, 8'h00);
    cyc(1'b1, 16'hC004, 8'h00);
    cyc(1'b1, 16'hC000, 8'h00);
    check("R7 cleanup", mode_flags[8:7], 0);
  endtask

  task automatic t_gate;
    sys_enh = 1'b0; sys_gfx = 1'b0;
    cyc(1'b1, 16'hC001, 8'h00);
    check("R6 gated off", mode_flags[0], 0);
    cyc(1'b0, 16'hC051, 8'h00);
    check("R7 text any class", mode_flags[5], 1);
    cyc(1'b1, 16'hC053, 8'h00);
    check("R7 mix set", mode_flags[6], 1);
    cyc(1'b1, 16'hC021, 8'h80);
    check("R8 gated off", mode_flags[9], 0);
    cyc(1'b0, 16'hC05E, 8'h00);
    check("R9 arm gated", mode_flags[10], 0);
    cyc(1'b0, 16'hC050, 8'h00);
    check("R7 text clear", mode_flags[5], 0);
  endtask

  task automatic t_mono;
    sys_enh = 1'b1;
    cyc(1'b1, 16'hC021, 8'h80);
    check("R8 mono set", mode_flags[9], 1);
    cyc(1'b0, 16'hC021, 8'h00);
    check("R8 read ignored", mode_flags[9], 1);
    cyc(1'b1, 16'hC021, 8'h7F);
    check("R8 mono clear", mode_flags[9], 0);
  endtask

  task automatic t_dbl;
    sys_enh = 1'b1;
    cyc(1'b1, 16'hC00D, 8'h00);
    check("R6 wide set", mode_flags[3], 1);
    cyc(1'b0, 16'hC05E, 8'h00);
    check("R9 armed", mode_flags[10], 1);
    cyc(1'b0, 16'hC05F, 8'h00);
    check("R9 first shift", dbl_mode, 2'b01);
    check("R9 disarmed", mode_flags[10], 0);
    cyc(1'b0, 16'hC05F, 8'h00);
    check("R9 idle strobe", dbl_mode, 2'b01);
    cyc(1'b1, 16'hC05E, 8'h00);
    cyc(1'b1, 16'hC00C, 8'h00);
    cyc(1'b1, 16'hC05F, 8'h00);
    check("R9 second shift", dbl_mode, 2'b10);
  endtask

  task automatic t_lock;
    sys_enh = 1'b0; sys_gfx = 1'b1;
    cyc(1'b1, 16'hC07E, 8'h00);
    check("R10 gfx only ignored", mode_flags[11], 0);
    sys_enh = 1'b1; sys_gfx = 1'b0;
    cyc(1'b0, 16'hC07E, 8'h00);
    check("R10 read ignored", mode_flags[11], 0);
    cyc(1'b1, 16'hC07E, 8'h00);
    check("R10 lock set", mode_flags[11], 1);
    cyc(1'b1, 16'hC07F, 8'h00);
    check("R10 lock clear", mode_flags[11], 0);
  endtask

  task automatic t_colour;
    sys_enh = 1'b1; sys_gfx = 1'b0;
    cyc(1'b1, 16'hC022, 8'hA5);
    check("R11 gated off", text_color, 0);
    sys_gfx = 1'b1;
    cyc(1'b1, 16'hC022, 8'hA5);
    check("R11 text colour", text_color, 8'hA5);
    cyc(1'b1, 16'hC034, 8'h3C);
    check("R11 border", border_color, 4'hC);
    cyc(1'b0, 16'hC034, 8'h07);
    check("R11 read ignored", border_color, 4'hC);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_main();
    t_auxwr();
    t_pgstore();
    t_gate();
    t_mono();
    t_dbl();
    t_lock();
    t_colour();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule